// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Packed-BCD Arithmetic

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. An operation code selects one of eleven functions applied to the accumulator operand and a memory operand: add with carry, subtract with borrow, compare, three bitwise logic operations, a bit test, and four single-bit shifts and rotates. The 8-bit result is combinational. The four condition flags are held in registers inside the block.

Negative, zero, carry and overflow each have their own register. On a clock edge a flag register loads a new value only when the current operation defines that flag. A flag the operation does not define keeps its old value. A registered enable for each flag shows which flags the most recent operation wrote.

When the decimal input is high, add and subtract treat both operands as two packed BCD digits. A nibble correction is applied after the binary sum is formed. Negative, zero and overflow are taken from the binary sum before this correction. Carry is taken from the corrected value. The register file, instruction sequencing and memory writeback belong to the surrounding processor.

Top module: `alu8_bcd`

## Requirements
- R1: Operation code 0 (add), decimal low: result = (A + M + carryIn) mod 256; flagC = bit 8 of that sum; flagN = result bit 7; flagZ = (result == 0); flagV = bit 7 of (sum XOR A) AND (sum XOR M). All four enables are set.
- R2: Operation code 0 with decimal high: S = A + M + carryIn, computed in 16 bits. flagN, flagZ and flagV are taken from S as in R1. S is then increased by 3 × ((((S + 0x66) XOR A XOR M) >> 3) AND 0x22), modulo 65536. The result is the low byte of this corrected value, and flagC = 1 when any of its bits 15..8 is set.
- R3: Operation code 1 (subtract): the operand used is (M XOR 0xFF). With decimal high, 0x66 is then subtracted from that operand, modulo 65536. The R1/R2 path then runs with this operand in place of M.
- R4: Operation code 2 (compare): result equals A. flagN and flagZ come from (A − M) mod 256, and flagC = (A ≥ M) unsigned. flagV is unchanged. The N, Z and C enables are set.
- R5: Operation codes 3, 4 and 5 give A AND M, A OR M and A XOR M. flagN and flagZ follow the result, flagC and flagV are unchanged, and only the N and Z enables are set.
- R6: Operation code 6 (bit test): result equals A. flagZ = ((A AND M) == 0), flagN = M bit 7, flagV = M bit 6, and flagC is unchanged.
- R7: Operation code 7 shifts A left and operation code 8 shifts A right, each by one bit with a 0 shifted in. flagC receives the bit shifted out (bit 7 for a left shift, bit 0 for a right shift). flagN and flagZ follow the result, and flagV is unchanged.
- R8: Operation codes 9 and 10 rotate A left and right through carry. carryIn fills bit 0 (left rotate) or bit 7 (right rotate). flags are set as in R7.
- R9: Operation codes 11 to 15 are idle: result equals A, all enables clear, and all flags unchanged. Flags change only on a rising clock edge.
- R10: While rst_n is low, all four flags and all four enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| opCode | input | 4 | Operation select (see requirements) |
| aIn | input | 8 | Accumulator operand |
| mIn | input | 8 | Memory operand |
| carryIn | input | 1 | Carry into add, subtract and rotate |
| decimalIn | input | 1 | Selects packed-BCD add/subtract |
| result | output | 8 | Combinational result |
| flagN | output | 1 | Registered negative flag |
| flagZ | output | 1 | Registered zero flag |
| flagC | output | 1 | Registered carry flag |
| flagV | output | 1 | Registered overflow flag |
| updN | output | 1 | Last operation wrote flagN |
| updZ | output | 1 | Last operation wrote flagZ |
| updC | output | 1 | Last operation wrote flagC |
| updV | output | 1 | Last operation wrote flagV |

## Verification
A wrong decode strobe or a wrong correction term shows on `result` during the same cycle the operation is applied. A wrong flag shows on the flag outputs one clock edge later. A flag register that is written when it should not be stays hidden until an operation that depends on that flag runs. For that reason, each logic, bit-test and compare operation is checked against the flag values left by the previous operation. Add and subtract are swept over every A/M pair, with the decimal and carry inputs varied along the sweep. This exposes errors in the nibble correction and in the wrapped decimal-subtract operand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int WIDE_W = 2 * DATA_W;
  localparam int OP_W   = 4;

  localparam logic [WIDE_W-1:0] BCD_BIAS = WIDE_W'('h66);
  localparam logic [WIDE_W-1:0] BCD_MASK = WIDE_W'('h22);

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB = 4'd1;
  localparam logic [OP_W-1:0] OP_CMP = 4'd2;
  localparam logic [OP_W-1:0] OP_AND = 4'd3;
  localparam logic [OP_W-1:0] OP_OR  = 4'd4;
  localparam logic [OP_W-1:0] OP_XOR = 4'd5;
  localparam logic [OP_W-1:0] OP_BIT = 4'd6;
  localparam logic [OP_W-1:0] OP_SHL = 4'd7;
  localparam logic [OP_W-1:0] OP_SHR = 4'd8;
  localparam logic [OP_W-1:0] OP_ROL = 4'd9;
  localparam logic [OP_W-1:0] OP_ROR = 4'd10;

  typedef enum logic [2:0] {RS_PASS, RS_SUM, RS_AND, RS_OR, RS_XOR, RS_SHIFT} res_sel_e;
  typedef enum logic [1:0] {NZ_RES, NZ_SUM, NZ_CMP, NZ_BIT} nz_sel_e;
  typedef enum logic [1:0] {C_SUM, C_CMP, C_SHIFT} c_sel_e;
  typedef enum logic {V_SUM, V_BIT} v_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    res_sel_e resSel;
    nz_sel_e  nzSel;
    c_sel_e   cSel;
    v_sel_e   vSel;
    logic     subtract;
    logic     decimal;
    logic     shiftRight;
    logic     rotate;
    flags_t   upd;
  } strobe_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            decimalIn,
  output strobe_t         strobe
);
  always_comb begin
    strobe            = '0;
    strobe.resSel     = RS_PASS;
    strobe.nzSel      = NZ_RES;
    strobe.cSel       = C_SUM;
    strobe.vSel       = V_SUM;
    strobe.decimal    = decimalIn;
    unique case (opCode)
      OP_ADD, OP_SUB: begin
        strobe.resSel   = RS_SUM;
        strobe.nzSel    = NZ_SUM;
        strobe.subtract = (opCode == OP_SUB);
        strobe.upd      = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
      end
      OP_CMP: begin
        strobe.nzSel = NZ_CMP;
        strobe.cSel  = C_CMP;
        strobe.upd   = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobe.resSel = (opCode == OP_AND) ? RS_AND :
                        (opCode == OP_OR)  ? RS_OR  : RS_XOR;
        strobe.upd    = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_BIT: begin
        strobe.nzSel = NZ_BIT;
        strobe.vSel  = V_BIT;
        strobe.upd   = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        strobe.resSel     = RS_SHIFT;
        strobe.cSel       = C_SHIFT;
        strobe.shiftRight = (opCode == OP_SHR) || (opCode == OP_ROR);
        strobe.rotate     = (opCode == OP_ROL) || (opCode == OP_ROR);
        strobe.upd        = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
(
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] mIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output flags_t            rawFlags
);
  logic [WIDE_W-1:0] aWide;
  logic [WIDE_W-1:0] opndWide;
  logic [WIDE_W-1:0] sumWide;
  logic [WIDE_W-1:0] fixWide;
  logic [WIDE_W-1:0] corrWide;
  logic              sumOvf;
  logic [DATA_W:0]   cmpDiff;
  logic [DATA_W-1:0] shiftOut;
  logic              shiftCarry;
  logic              fillBit;
  logic [DATA_W-1:0] nzSource;

  // adder with optional packed-BCD correction
  always_comb begin
    aWide    = {{DATA_W{1'b0}}, aIn};
    opndWide = {{DATA_W{1'b0}}, (strobe.subtract ? ~mIn : mIn)};
    if (strobe.subtract && strobe.decimal) opndWide = opndWide - BCD_BIAS;
    sumWide  = aWide + opndWide + {{(WIDE_W-1){1'b0}}, carryIn};
    sumOvf   = (sumWide[DATA_W-1] ^ aIn[DATA_W-1]) & (sumWide[DATA_W-1] ^ opndWide[DATA_W-1]);
    fixWide  = strobe.decimal ?
               ((((sumWide + BCD_BIAS) ^ aWide ^ opndWide) >> 3) & BCD_MASK) : '0;
    corrWide = sumWide + fixWide + (fixWide << 1);
  end

  // compare subtractor, independent of carry and decimal inputs
  assign cmpDiff = {1'b0, aIn} - {1'b0, mIn};

  // shifter / rotator
  always_comb begin
    fillBit = strobe.rotate ? carryIn : 1'b0;
    if (strobe.shiftRight) begin
      shiftOut   = {fillBit, aIn[DATA_W-1:1]};
      shiftCarry = aIn[0];
    end else begin
      shiftOut   = {aIn[DATA_W-2:0], fillBit};
      shiftCarry = aIn[DATA_W-1];
    end
  end

  always_comb begin
    unique case (strobe.resSel)
      RS_SUM:   resultOut = corrWide[DATA_W-1:0];
      RS_AND:   resultOut = aIn & mIn;
      RS_OR:    resultOut = aIn | mIn;
      RS_XOR:   resultOut = aIn ^ mIn;
      RS_SHIFT: resultOut = shiftOut;
      default:  resultOut = aIn;
    endcase
  end

  always_comb begin
    unique case (strobe.nzSel)
      NZ_SUM:  nzSource = sumWide[DATA_W-1:0];
      NZ_CMP:  nzSource = cmpDiff[DATA_W-1:0];
      NZ_BIT:  nzSource = aIn & mIn;
      default: nzSource = resultOut;
    endcase
    rawFlags.z = (nzSource == '0);
    rawFlags.n = (strobe.nzSel == NZ_BIT) ? mIn[DATA_W-1] : nzSource[DATA_W-1];
    unique case (strobe.cSel)
      C_CMP:   rawFlags.c = ~cmpDiff[DATA_W];
      C_SHIFT: rawFlags.c = shiftCarry;
      default: rawFlags.c = |corrWide[WIDE_W-1:DATA_W];
    endcase
    rawFlags.v = (strobe.vSel == V_BIT) ? mIn[DATA_W-2] : sumOvf;
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t updIn,
  input  flags_t rawFlags,
  output flags_t flagsQ,
  output flags_t updQ
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '0;
      updQ   <= '0;
    end else begin
      updQ <= updIn;
      if (updIn.n) flagsQ.n <= rawFlags.n;
      if (updIn.z) flagsQ.z <= rawFlags.z;
      if (updIn.c) flagsQ.c <= rawFlags.c;
      if (updIn.v) flagsQ.v <= rawFlags.v;
    end
  end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] mIn,
  input  logic              carryIn,
  input  logic              decimalIn,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              updN,
  output logic              updZ,
  output logic              updC,
  output logic              updV
);
  strobe_t strobe;
  flags_t  rawFlags;
  flags_t  flagsQ;
  flags_t  updQ;

  alu8_ctrl ctrl_i (
    .opCode    (opCode),
    .decimalIn (decimalIn),
    .strobe    (strobe)
  );

  alu8_dp dp_i (
    .strobe    (strobe),
    .aIn       (aIn),
    .mIn       (mIn),
    .carryIn   (carryIn),
    .resultOut (result),
    .rawFlags  (rawFlags)
  );

  alu8_flagreg flagreg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .updIn    (strobe.upd),
    .rawFlags (rawFlags),
    .flagsQ   (flagsQ),
    .updQ     (updQ)
  );

  assign {flagN, flagZ, flagC, flagV} = flagsQ;
  assign {updN, updZ, updC, updV}     = updQ;
endmodule

// File: rtl/alu8_bcd_checker.sv
module alu8_bcd_checker
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] mIn,
  input logic              carryIn,
  input logic              decimalIn,
  input logic [DATA_W-1:0] result,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              flagV,
  input logic              updN,
  input logic              updZ,
  input logic              updC,
  input logic              updV
);
  logic [DATA_W:0] binSum;
  assign binSum = {1'b0, aIn} + {1'b0, mIn} + {{DATA_W{1'b0}}, carryIn};

  AST_ADD_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_ADD && !decimalIn) |-> result == binSum[DATA_W-1:0]); // R1
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_ADD && !decimalIn) |=> flagC == $past(binSum[DATA_W])); // R1
  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_CMP) |-> result == aIn); // R4
  AST_CMP_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_CMP) |=> $stable(flagV)); // R4
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR) |=> ($stable(flagC) && $stable(flagV))); // R5
  AST_AND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_AND) |=> flagZ == ($past(aIn & mIn) == '0)); // R5
  AST_BIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_BIT) |=> (flagN == $past(mIn[DATA_W-1]) && flagV == $past(mIn[DATA_W-2]))); // R6
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_SHL) |=> flagC == $past(aIn[DATA_W-1])); // R7
  AST_ROL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_ROL) |-> result[0] == carryIn); // R8
  AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode > OP_ROR) |=> !(updN || updZ || updC || updV)); // R9
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode > OP_ROR) |-> result == aIn); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert ({flagN, flagZ, flagC, flagV, updN, updZ, updC, updV} == 8'h00); // R10
    end
  end
endmodule

bind alu8_bcd alu8_bcd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .opCode(opCode), .aIn(aIn), .mIn(mIn),
  .carryIn(carryIn), .decimalIn(decimalIn), .result(result),
  .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
  .updN(updN), .updZ(updZ), .updC(updC), .updV(updV)
);

// File: tb/alu8_bcd_tb_top.sv
`timescale 1ns/1ps
module alu8_bcd_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opCode = 4'd15;
  logic [7:0] aIn = 8'h00;
  logic [7:0] mIn = 8'h00;
  logic       carryIn = 1'b0;
  logic       decimalIn = 1'b0;
  logic [7:0] result;
  logic       flagN, flagZ, flagC, flagV, updN, updZ, updC, updV;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [3:0]  modelFlags = 4'h0;

  always #4 clk = ~clk;

  alu8_bcd dut_i (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .aIn(aIn), .mIn(mIn),
    .carryIn(carryIn), .decimalIn(decimalIn), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .updN(updN), .updZ(updZ), .updC(updC), .updV(updV)
  );

  // reference: returns {result, N,Z,C,V, updN,updZ,updC,updV}
  function automatic logic [15:0] refAlu(input int op, input int a, input int m,
                                         input int ci, input int dec, input logic [3:0] fin);
    int s, o;
    logic [7:0] r;
    logic n, z, c, v;
    logic [3:0] u;
    {n, z, c, v} = fin;
    r = 8'(a);
    u = 4'h0;
    case (op)
      0, 1: begin
        o = (op == 1) ? ((~m) & 255) : m;
        if (op == 1 && dec != 0) o = (o - 'h66) & 'hFFFF;
        s = (a + o + ci) & 'hFFFF;
        n = s[7];
        z = ((s & 255) == 0);
        v = (((s ^ a) & (s ^ o) & 'h80) != 0);
        if (dec != 0) s = (s + ((((s + 'h66) ^ a ^ o) >> 3) & 'h22) * 3) & 'hFFFF;
        c = ((s & 'hFF00) != 0);
        r = 8'(s);
        u = 4'b1111;
      end
      2: begin
        s = (a - m) & 255;
        n = s[7];
        z = (s == 0);
        c = (a >= m);
        u = 4'b1110;
      end
      3, 4, 5: begin
        r = (op == 3) ? 8'(a & m) : (op == 4) ? 8'(a | m) : 8'(a ^ m);
        n = r[7];
        z = (r == 0);
        u = 4'b1100;
      end
      6: begin
        z = ((a & m) == 0);
        n = m[7];
        v = m[6];
        u = 4'b1101;
      end
      7, 8, 9, 10: begin
        if (op == 7 || op == 9) begin
          c = a[7];
          r = {a[6:0], (op == 9) ? ci[0] : 1'b0};
        end else begin
          c = a[0];
          r = {(op == 10) ? ci[0] : 1'b0, a[7:1]};
        end
        n = r[7];
        z = (r == 0);
        u = 4'b1110;
      end
      default: ;
    endcase
    return {r, n, z, c, v, u};
  endfunction

  // driver: applies one operation and queues its expected outcome
  task automatic drive(input int op, input int a, input int m, input int ci,
                       input int dec, input string tag);
    logic [15:0] e;
    @(negedge clk);
    opCode = 4'(op); aIn = 8'(a); mIn = 8'(m);
    carryIn = ci[0]; decimalIn = dec[0];
    e = refAlu(op, a, m, ci, dec, modelFlags);
    modelFlags = e[7:4];
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: outputs settle after the edge, inputs stay until next negedge
  initial begin : monitor
    forever begin
      logic [15:0] e, got;
      string t;
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        got = {result, flagN, flagZ, flagC, flagV, updN, updZ, updC, updV};
        checks++;
        if (got !== e) begin
          fails++;
          $display("FAIL %s: op=%0d a=%02h m=%02h res=%02h nzcv=%b upd=%b expected res=%02h nzcv=%b upd=%b",
                   t, opCode, aIn, mIn, got[15:8], got[7:4], got[3:0], e[15:8], e[7:4], e[3:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
    $finish;
  end

  initial begin : stim
    string opTag [16];
    opTag = '{"R1", "R3", "R4", "R5", "R5", "R5", "R6", "R7", "R7", "R8", "R8",
              "R9", "R9", "R9", "R9", "R9"};
    // R10: reset state
    repeat (2) @(negedge clk);
    checks++;
    if ({flagN, flagZ, flagC, flagV, updN, updZ, updC, updV} !== 8'h00) begin
      fails++;
      $display("FAIL R10: flags/upd=%b expected 00000000",
               {flagN, flagZ, flagC, flagV, updN, updZ, updC, updV});
    end
    rst_n = 1'b1;

    // directed corner cases
    drive(0, 'h80, 'h80, 0, 0, "R1");  // signed overflow with carry
    drive(3, 'hFF, 'h0F, 0, 0, "R5");  // AND keeps C,V set
    drive(0, 'h09, 'h01, 0, 1, "R2");  // 0x10
    drive(0, 'h99, 'h01, 0, 1, "R2");  // 0x00, C=1, N from 0x9A
    drive(1, 'h10, 'h01, 1, 1, "R3");  // 0x09, C=1
    drive(1, 'h00, 'h01, 1, 1, "R3");  // borrow case
    drive(1, 'h20, 'hA0, 1, 1, "R3");  // wrapped operand
    drive(2, 'h40, 'h40, 0, 0, "R4");  // equal: Z=1 C=1
    drive(2, 'h10, 'h20, 0, 0, "R4");  // less: C=0 N=1
    drive(6, 'h0F, 'hC0, 0, 0, "R6");  // Z=1 N=1 V=1
    drive(8, 'h01, 'h00, 1, 0, "R7");  // shift right to zero, C=1
    drive(10, 'h00, 'h00, 1, 0, "R8"); // rotate carry into bit 7
    drive(9, 'h80, 'h00, 0, 0, "R8");  // rotate out bit 7
    drive(12, 'h5A, 'h33, 1, 1, "R9"); // idle

    // add and subtract over every operand pair
    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int m = 0; m < 256; m++) begin
          int dec, ci;
          dec = a[0] ^ m[1];
          ci  = m[0] ^ a[3];
          drive(op, a, m, ci, dec, (op == 1) ? "R3" : (dec != 0) ? "R2" : "R1");
        end
      end
    end

    // remaining operations, including idle codes
    for (int op = 2; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        drive(op, a, (a * 37 + 11) & 255, a[2], a[5], opTag[op]);
      end
    end

    @(negedge clk);
    opCode = 4'd15;
    repeat (3) @(posedge clk);
    #3;
    summary();
    $finish;
  end
endmodule